// File: doc/BRIEF.md
# Main-Path Cascaded Synthesizer Divider

This block turns the fast clock coming out of an RF prescaler into the main-port comparison signal that a phase/frequency detector compares against the reference. It is a chain of four stages. A fixed divide-by-3 comes first. A programmable counter follows, set from 64 to 127. Next is a fixed divide-by-2, which squares the counter's terminal-count pulses. The last stage is a post-scaler that either passes the signal through or halves it again.

All stages run on the one input clock. Each stage advances on a clock-enable pulse from the stage before it, so no derived clocks exist. A new counter setting is taken only at a terminal count. A new post-scaler setting is taken only at the start of an output period. Changing the settings therefore never produces a short or glitched period. Next to the comparison signal, the block gives a single-cycle marker for every transition of that signal, for logic that counts or times the edges.

Top module: `main_path_divider`

## Requirements
- R1: One full period of `cmp_out` lasts 3 × N × 2 × M input clock cycles. N is the clamped counter setting. M is 1 when `post_pass` is HIGH and 2 when it is LOW.
- R2: With `post_pass` LOW, the post-scaler divides by 2. `cmp_out` is then HIGH and LOW for exactly equal numbers of cycles (6 × N each).
- R3: With `post_pass` HIGH, the post-scaler divides by 1. `cmp_out` is then HIGH and LOW for 3 × N cycles each.
- R4: An `n_value` below 64 acts exactly like 64. For example, 10 and 0 both give the period of N = 64.
- R5: A new `n_value` is adopted only at the counter's terminal count. The half-period in progress when the value changes keeps the old length, and the next half-period uses the new one.
- R6: `cmp_edge` is HIGH for exactly one cycle: the first cycle in which `cmp_out` shows a new level. It is LOW in every other cycle.
- R7: While `rst_n` is LOW at a clock edge, `cmp_out` and `cmp_edge` are LOW. The counter starts from the setting 71 and the post-scaler starts at divide-by-1, whatever the inputs are. After reset is released, `cmp_out` first rises at the 213th rising clock edge.
- R8: A change of `post_pass` is adopted only when `cmp_out` rises. A high phase in progress ends on its old schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock from the RF prescaler |
| rst_n | input | 1 | Synchronous reset, active LOW |
| n_value | input | 7 | Programmable counter setting, unsigned binary (64..127 useful) |
| post_pass | input | 1 | Post-scaler select: HIGH divide-by-1, LOW divide-by-2 |
| cmp_out | output | 1 | Comparison-rate signal to the phase detector |
| cmp_edge | output | 1 | One-cycle marker at each transition of `cmp_out` |

## Verification
The bench builds the block with its default parameters: a 7-bit setting, a floor of 64, a first stage of 3 and a reset setting of 71. With these values the longest period is 1524 cycles, so each table vector can run several full periods within the cycle budget. The vectors cover both ends of the counter range in both post-scaler modes. They also cover settings that must be clamped, which exercises the floor. The reset setting of 71 gives the first output edge a fixed, predictable cycle, and this cycle also shows that the inputs are ignored at reset.

// File: rtl/mpd_pkg.sv
// Package mpd_pkg
// Holds the types shared across the main-path divider. The post-scaler mode
// names its two settings so that the selection logic reads as intent rather
// than as a raw bit.
package mpd_pkg;

    typedef enum logic {
        POST_HALVE = 1'b0,
        POST_PASS  = 1'b1
    } post_mode_e;

endpackage

// File: rtl/mpd_prescale.sv
// Module mpd_prescale
// Fixed first-stage divider. It produces a one-cycle enable once every DIV
// input cycles. It assumes DIV >= 2 and a synchronous active-low reset.
// After reset the first enable comes in the DIV-th cycle.
module mpd_prescale #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ce_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter that wraps after DIV states.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign ce_o = (cnt_q == LAST);

    // R1: enables are spaced apart, never back to back
    p_ce_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |=> !ce_o);

endmodule

// File: rtl/mpd_ncount.sv
// Module mpd_ncount
// Programmable divide-by-N stage. It is gated by the first-stage enable.
// The active ratio is held in a register and reloaded from n_i only at the
// terminal count, which keeps a mid-count change from shortening a period.
// Settings below N_MIN are raised to N_MIN. It assumes RESET_N >= N_MIN.
module mpd_ncount #(
    parameter int N_W     = 7,
    parameter int N_MIN   = 64,
    parameter int RESET_N = 71
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_i,
    input  logic [N_W-1:0] n_i,
    output logic           tc_o
);
    localparam logic [N_W-1:0] FLOOR = N_W'(N_MIN);
    localparam logic [N_W-1:0] START = N_W'(RESET_N);

    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] act_n_q;
    logic [N_W-1:0] n_clamped;

    // Raise settings under the floor to the floor.
    always_comb begin
        n_clamped = (n_i < FLOOR) ? FLOOR : n_i;
    end

    assign tc_o = ce_i && (cnt_q == act_n_q - 1'b1);

    // Count enables; at terminal count restart and adopt the new ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_n_q <= START;
        end else if (tc_o) begin
            cnt_q   <= '0;
            act_n_q <= n_clamped;
        end else if (ce_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R1: the count never leaves the active range
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_n_q);

    // R4: the active ratio never drops below the floor
    p_ratio_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_n_q >= FLOOR);

    // R5: the active ratio changes only after a terminal count
    p_ratio_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_o |=> $stable(act_n_q));

endmodule

// File: rtl/mpd_post.sv
// Module mpd_post
// Output stage. It sees the terminal-count pulse and the divide-by-2 state
// that the pulse is about to flip. In pass mode the output follows that
// state. In halve mode the output toggles on each of its rising moves.
// The mode is taken from bypass_i only when the output rises, so a period
// is never cut short. edge_o marks the first cycle of each new level.
module mpd_post
    import mpd_pkg::*;
#(
    parameter bit RESET_PASS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_i,
    input  logic stage_i,
    input  logic bypass_i,
    output logic out_o,
    output logic edge_o
);
    post_mode_e mode_q;
    logic       out_q;
    logic       edge_q;
    logic       out_d;
    logic       rise_evt;
    logic       fall_evt;

    assign rise_evt = tc_i && !stage_i;
    assign fall_evt = tc_i &&  stage_i;

    // Next output level for the current mode.
    always_comb begin
        out_d = out_q;
        if (rise_evt)
            out_d = (mode_q == POST_PASS) ? 1'b1 : ~out_q;
        else if (fall_evt && mode_q == POST_PASS)
            out_d = 1'b0;
    end

    // Output register, edge marker and mode adopted at each output rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            edge_q <= 1'b0;
            mode_q <= RESET_PASS ? POST_PASS : POST_HALVE;
        end else begin
            out_q  <= out_d;
            edge_q <= (out_d != out_q);
            if (out_d && !out_q)
                mode_q <= bypass_i ? POST_PASS : POST_HALVE;
        end
    end

    assign out_o  = out_q;
    assign edge_o = edge_q;

    // R6: the marker coincides with a changed output level
    p_edge_marks_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q |-> !$stable(out_q));

    // R8: the mode moves only together with an output rise
    p_mode_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $rose(out_q));

endmodule

// File: rtl/main_path_divider.sv
// Module main_path_divider
// Top of the main-path divider chain: fixed prescale, programmable counter,
// fixed divide-by-2 and selectable post-scaler. Every stage runs on clk and
// uses clock enables. It assumes a synchronous active-low reset held for at
// least one clock edge.
module main_path_divider #(
    parameter int N_W        = 7,
    parameter int N_MIN      = 64,
    parameter int PRE_DIV    = 3,
    parameter int RESET_N    = 71,
    parameter bit RESET_PASS = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_value,
    input  logic           post_pass,
    output logic           cmp_out,
    output logic           cmp_edge
);
    logic pre_ce;
    logic n_tc;
    logic div2_q;

    mpd_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_o  (pre_ce)
    );

    mpd_ncount #(.N_W(N_W), .N_MIN(N_MIN), .RESET_N(RESET_N)) u_ncnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_i  (pre_ce),
        .n_i   (n_value),
        .tc_o  (n_tc)
    );

    // Fixed divide-by-2: flip on every terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    div2_q <= 1'b0;
        else if (n_tc) div2_q <= ~div2_q;
    end

    mpd_post #(.RESET_PASS(RESET_PASS)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_i     (n_tc),
        .stage_i  (div2_q),
        .bypass_i (post_pass),
        .out_o    (cmp_out),
        .edge_o   (cmp_edge)
    );

    // R1: the half-rate stage moves only on a counter terminal count
    p_div2_on_tc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !n_tc |=> $stable(div2_q));

endmodule

// File: tb/test_main_path_divider.sv
`timescale 1ns/1ps
module test_main_path_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] n_value = 7'd71;
    logic       post_pass = 1'b1;
    logic       cmp_out;
    logic       cmp_edge;

    int checks = 0;
    int fails  = 0;
    int edge_bad = 0;

    localparam int NV = 9;
    localparam int LIMIT = 5000;
    // Stimulus N, post-scaler select, expected full period in cycles
    localparam int VN[NV] = '{64, 127, 71, 100, 64, 127, 10, 0, 90};
    localparam int VB[NV] = '{1,  1,   1,  0,   0,  0,   1,  0, 1};
    localparam int VP[NV] = '{384, 762, 426, 1200, 768, 1524, 384, 768, 540};

    always #4 clk = ~clk;

    main_path_divider i_main_path_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_value   (n_value),
        .post_pass (post_pass),
        .cmp_out   (cmp_out),
        .cmp_edge  (cmp_edge)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until cmp_out shows the given level; also audit cmp_edge (R6).
    task automatic run_until(input logic level, output int n);
        logic prev;
        n = 0;
        prev = cmp_out;
        while (n < LIMIT) begin
            @(negedge clk);
            n++;
            if (cmp_edge !== (cmp_out !== prev)) edge_bad++;
            prev = cmp_out;
            if (cmp_out === level) break;
        end
    endtask

    task automatic sync_rise();
        int d;
        run_until(1'b0, d);
        run_until(1'b1, d);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cmp_out === 1'b0, "R7 out in reset", int'(cmp_out), 0);
        check(cmp_edge === 1'b0, "R7 edge in reset", int'(cmp_edge), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int h, l, n;
        // R7: reset state and first rise with default settings
        do_reset();
        run_until(1'b1, n);
        check(n == 213, "R7 first rise", n, 213);

        // R7: inputs ignored by reset, start still uses the reset setting
        n_value = 7'd100;
        post_pass = 1'b0;
        do_reset();
        run_until(1'b1, n);
        check(n == 213, "R7 reset ignores inputs", n, 213);

        // Table walk: R1 period, R2/R3 duty, R4 clamp, R6 edge marker
        for (int i = 0; i < NV; i++) begin
            n_value = 7'(VN[i]);
            post_pass = VB[i][0];
            sync_rise();
            sync_rise();
            edge_bad = 0;
            run_until(1'b0, h);
            run_until(1'b1, l);
            check(h + l == VP[i], (VN[i] < 64) ? "R4 clamped period" : "R1 period", h + l, VP[i]);
            check(h == l, VB[i] ? "R3 pass duty" : "R2 halve duty", h, l);
            check(edge_bad == 0, "R6 edge marker", edge_bad, 0);
        end

        // R5: N change mid high phase keeps the old half-period
        n_value = 7'd64;
        post_pass = 1'b1;
        sync_rise();
        sync_rise();
        repeat (10) @(negedge clk);
        n_value = 7'd120;
        run_until(1'b0, h);
        check(h + 10 == 192, "R5 old half kept", h + 10, 192);
        run_until(1'b1, l);
        check(l == 360, "R5 new half adopted", l, 360);

        // R8: post-scaler change in high phase adopted at next rise
        n_value = 7'd80;
        post_pass = 1'b1;
        sync_rise();
        sync_rise();
        repeat (5) @(negedge clk);
        post_pass = 1'b0;
        run_until(1'b0, h);
        check(h + 5 == 240, "R8 high kept", h + 5, 240);
        run_until(1'b1, l);
        check(l == 240, "R8 low kept", l, 240);
        run_until(1'b0, h);
        check(h == 480, "R8 halve after rise", h, 480);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule